// File: doc/BRIEF.md
# Write-First Register File with Same-Cycle Bypass

This block is the architectural register file of an in-order pipeline: 32 entries of 32 bits, two combinational read ports used by the decode stage and one write port fed by the writeback stage. Data written by writeback is stored on the rising clock edge. A read issued in the same cycle to the same register still returns the incoming value, because a bypass path inside the block carries it around the storage array.

From outside, the block therefore behaves as if the write happened in the first half of the cycle and the reads in the second half. It uses a single clock edge, and the decode stage needs neither an extra stall cycle nor a writeback-to-decode forward.

Register 0 is a constant zero. Writes to it are discarded, and the bypass never fires for it. An active-low asynchronous reset clears every entry.

Top module: `regfile_bypass`

## Requirements
- R1: While reset is held and after it is released, every register reads 0 on both ports until it is written.
- R2: Address 0 reads 0 on both read ports in every cycle.
- R3: A write with wr_en_i high to address 0 is dropped. Reads of address 0 return 0 in the same cycle and in every later cycle.
- R4: When wr_en_i is high and wr_addr_i is non-zero, wr_data_i is stored at the rising edge. A read of that address returns it from the next cycle on.
- R5: When wr_en_i is low, no register changes at the clock edge.
- R6: Port A returns wr_data_i in the same cycle when wr_en_i is high and rd_addr_a_i equals a non-zero wr_addr_i.
- R7: Port B applies the same bypass rule as port A, decided independently of port A. The port whose address does not match reads the stored value.
- R8: When both read ports address the register being written, both return wr_data_i in that cycle.
- R9: When wr_en_i is low, a matching wr_addr_i causes no bypass. The read returns the stored value.
- R10: Asserting rst_ni between clock edges clears all registers at once, without waiting for an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; stores data on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_addr_a_i | input | 5 | Read address, port A |
| rd_data_a_o | output | 32 | Read data, port A (combinational) |
| rd_addr_b_i | input | 5 | Read address, port B |
| rd_data_b_o | output | 32 | Read data, port B (combinational) |
| wr_en_i | input | 1 | Write enable from writeback |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 32 | Write data |

## Verification
A writeback store and a decode read of the same register can fall in the same cycle. Either read port, or both at once, can be the one that collides with the write.

The bench provokes this by driving a write address equal to one or both read addresses while the write enable is high. It also drives the same collision with the enable low, and with the zero register as the target.

Each read is judged against a reference array that applies the pending write before the read. The bench then confirms on the next cycle that the value was also stored.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_NUM_RD = 2;
  localparam int unsigned RF_PORT_A = 0;
  localparam int unsigned RF_PORT_B = 1;
endpackage

// File: rtl/rf_array.sv
module rf_array #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] regs_o [NUM_REGS]
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs_o[i] = '0;
    end else begin : g_store
      logic hit;
      assign hit = wr_en_i && (wr_addr_i == ADDR_W'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  regs_o[i] <= '0;
        else if (hit) regs_o[i] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [DATA_W-1:0] regs_i [NUM_REGS],
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic is_zero, byp_hit;
  assign is_zero = (rd_addr_i == '0);
  assign byp_hit = wr_en_i && (wr_addr_i == rd_addr_i);

  // zero beats bypass beats array
  always_comb begin
    if (is_zero)      rd_data_o = '0;
    else if (byp_hit) rd_data_o = wr_data_i;
    else              rd_data_o = regs_i[rd_addr_i];
  end
endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [ADDR_W-1:0] rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  import rf_pkg::*;

  logic [DATA_W-1:0] regs      [NUM_REGS];
  logic [ADDR_W-1:0] rd_addr   [RF_NUM_RD];
  logic [DATA_W-1:0] rd_data   [RF_NUM_RD];

  assign rd_addr[RF_PORT_A] = rd_addr_a_i;
  assign rd_addr[RF_PORT_B] = rd_addr_b_i;
  assign rd_data_a_o        = rd_data[RF_PORT_A];
  assign rd_data_b_o        = rd_data[RF_PORT_B];

  rf_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  for (genvar p = 0; p < RF_NUM_RD; p++) begin : g_rd
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port (
      .regs_i    (regs),
      .rd_addr_i (rd_addr[p]),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_data_o (rd_data[p])
    );
  end
endmodule

// File: rtl/rf_bypass_chk.sv
module rf_bypass_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rd_addr_a_i,
  input logic [DATA_W-1:0] rd_data_a_o,
  input logic [ADDR_W-1:0] rd_addr_b_i,
  input logic [DATA_W-1:0] rd_data_b_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i
);
  assert_zero_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0) |-> (rd_data_a_o == '0));
  assert_zero_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_b_i == '0) |-> (rd_data_b_o == '0));

  assert_bypass_a_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0 && wr_addr_i == rd_addr_a_i) |-> (rd_data_a_o == wr_data_i));
  assert_bypass_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0 && wr_addr_i == rd_addr_b_i) |-> (rd_data_b_o == wr_data_i));

  // stored value seen next cycle unless overwritten again
  assert_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i) && $past(wr_addr_i) != '0
     && rd_addr_a_i == $past(wr_addr_i) && !(wr_en_i && wr_addr_i == rd_addr_a_i))
    |-> (rd_data_a_o == $past(wr_data_i)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(wr_en_i) && $stable(rd_addr_a_i) && !wr_en_i)
    |-> $stable(rd_data_a_o));
endmodule

bind regfile_bypass rf_bypass_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_addr_a_i (rd_addr_a_i),
  .rd_data_a_o (rd_data_a_o),
  .rd_addr_b_i (rd_addr_b_i),
  .rd_data_b_o (rd_data_b_o),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i)
);

// File: tb/sim_regfile_bypass.sv
`timescale 1ns/1ps
module sim_regfile_bypass;
  localparam int NREG = 32;
  localparam int NVEC = 12;
  // vector: {we, wa[4:0], wd[31:0], ra[4:0], rb[4:0]}
  localparam logic [47:0] VECS [NVEC] = '{
    {1'b1, 5'd3,  32'h1111_1111, 5'd3,  5'd0},
    {1'b0, 5'd3,  32'hDEAD_BEEF, 5'd3,  5'd3},
    {1'b1, 5'd7,  32'h0000_0077, 5'd1,  5'd7},
    {1'b1, 5'd7,  32'h0000_0078, 5'd7,  5'd7},
    {1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd0},
    {1'b0, 5'd0,  32'h0000_0000, 5'd0,  5'd7},
    {1'b1, 5'd31, 32'h8000_0001, 5'd31, 5'd30},
    {1'b1, 5'd30, 32'h0000_3030, 5'd31, 5'd30},
    {1'b0, 5'd31, 32'h0000_1234, 5'd31, 5'd31},
    {1'b1, 5'd3,  32'h0000_0033, 5'd7,  5'd3},
    {1'b1, 5'd5,  32'h0000_0055, 5'd3,  5'd30},
    {1'b1, 5'd5,  32'h0000_0056, 5'd5,  5'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] ra = '0, rb = '0, wa = '0;
  logic [31:0] wd = '0, qa, qb;
  logic we = 1'b0;
  logic [31:0] model [NREG];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  regfile_bypass u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_addr_a_i(ra), .rd_data_a_o(qa),
    .rd_addr_b_i(rb), .rd_data_b_o(qb),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_rd(input logic [4:0] a);
    if (a == 0) return '0;
    if (we && wa == a) return wd;
    return model[a];
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NREG; i++) model[i] = '0;
  endtask

  // drive at negedge, check 1ns later, commit model for following posedge
  task automatic step(input logic w, input logic [4:0] a_w, input logic [31:0] d,
                      input logic [4:0] a, input logic [4:0] b,
                      input string tag_a, input string tag_b);
    @(negedge clk);
    we = w; wa = a_w; wd = d; ra = a; rb = b;
    #1;
    check(tag_a, qa, expect_rd(a));
    check(tag_b, qb, expect_rd(b));
    if (w && a_w != 0) model[a_w] = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R1: zero during reset
    ra = 5'd9; rb = 5'd17; #1;
    check("R1", qa, 32'h0); check("R1", qb, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    // R1: every register zero after release
    for (int i = 0; i < NREG; i++) step(1'b0, 5'd0, 32'h0, 5'(i), 5'(NREG-1-i), "R1", "R1");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [47:0] v;
      string ta, tb;
      v = VECS[i];
      ta = (v[9:5] == 0) ? "R2" : (v[47] && v[46:42] == v[9:5]) ? "R6" : "R4";
      tb = (v[4:0] == 0) ? "R2" : (v[47] && v[46:42] == v[4:0]) ? "R7" : "R4";
      step(v[47], v[46:42], v[41:10], v[9:5], v[4:0], ta, tb);
    end

    // R3: write to zero dropped, same cycle and next
    step(1'b1, 5'd0, 32'hCAFE_F00D, 5'd0, 5'd0, "R3", "R3");
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R3", "R3");
    check("R3", qa, 32'h0);

    // R9: matching address with enable low gives stored value
    step(1'b1, 5'd12, 32'h0000_0C0C, 5'd1, 5'd1, "R4", "R4");
    step(1'b0, 5'd12, 32'hBAD0_BAD0, 5'd12, 5'd12, "R9", "R9");
    check("R9", qa, 32'h0000_0C0C);
    // R5: still unchanged after the edge
    step(1'b0, 5'd12, 32'hBAD1_BAD1, 5'd12, 5'd1, "R5", "R5");
    check("R5", qa, 32'h0000_0C0C);

    // R8: both ports bypass the same register
    step(1'b1, 5'd20, 32'h2020_2020, 5'd20, 5'd20, "R8", "R8");
    check("R8", qb, 32'h2020_2020);
    // R7: port B bypasses while port A reads array
    step(1'b1, 5'd21, 32'h2121_2121, 5'd20, 5'd21, "R7", "R7");
    check("R7", qa, 32'h2020_2020);

    // R10: asynchronous reset between edges
    @(negedge clk);
    we = 1'b0; ra = 5'd20; rb = 5'd21; #0.5;
    rst_n = 1'b0; #0.5;
    check("R10", qa, 32'h0); check("R10", qb, 32'h0);
    model_clear();
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 5'd0, 32'h0, 5'd12, 5'd31, "R10", "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule